// File: doc/BRIEF.md
# Tick-Gated Data Latch Slice with Monitor Snapshot

This block is one slice of a wide data latch. A bank of input bits is loaded into a register only when a tick strobe and a tick enable are both high on the same system clock edge. The register drives the output bus directly and keeps its value between enabled ticks. The slice width is a parameter from 1 to 32 bits, so slices of different widths can sit side by side and make up a wider latch.

A second register bank takes a snapshot of the latched word when a separate capture strobe is high. A 16-bit synchronous register port lets software read that snapshot, split over two monitor words with unused upper bits held at zero. It also gives access to a small control/status register with an interrupt enable bit and an interrupt request bit, and to three spare read/write words. An active-low status output goes low only while both interrupt bits are set.

All inputs are synchronous enables in one clock domain. Reads return data and a valid flag one cycle after the read strobe.

Top module: `latch_monitor_slice`

## Requirements
- R1: When `tick_i` and `tick_en_i` are both high at a clock edge, `dout_o` shows the `din_i` value sampled at that edge, starting from the next cycle.
- R2: When either `tick_i` or `tick_en_i` is low at a clock edge, `dout_o` keeps its value.
- R3: When `capture_i` is high at an edge, the monitor snapshot takes the latched word as it stood before that edge. A tick in the same cycle therefore does not reach the snapshot. Reads return the snapshot, never the live latch.
- R4: Address 0 holds bit 0 = interrupt enable (R/W) and bit 1 = interrupt request (R/W). Bit 2 is read-only and equals enable AND request. Bits 15:3 read as zero.
- R5: `status_n_o` is the inverse of address 0 bit 2, and it is high after reset.
- R6: Addresses 1, 2 and 3 are 16-bit read/write words. Writes to them change no other register and no output.
- R7: Address 8 returns snapshot bits 15:0 and address 9 returns snapshot bits 31:16. Bit positions at or above `DATA_W` read as zero, so a slice of 16 bits or less reads address 9 as zero.
- R8: Reads of addresses 4–7 and 10–15 return zero. Writes to addresses 8 and 9, and writes to bit 2 of address 0, have no effect.
- R9: `bus_rvalid_o` is high exactly one cycle after a cycle with `bus_rd_i` high, with `bus_rdata_o` valid in that cycle. It is low otherwise.
- R10: While `rst_n` is low at an edge, the latch, the snapshot, both interrupt bits, the spare words and the read valid flag are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Tick strobe for the data latch |
| tick_en_i | input | 1 | Enable combined with the tick |
| capture_i | input | 1 | Monitor snapshot strobe |
| din_i | input | DATA_W | Data to latch |
| dout_o | output | DATA_W | Latched data bus |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 16 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| status_n_o | output | 1 | Active-low interrupt status line |

## Verification
The assertions assume that every strobe and bus input is a known, clock-synchronous level. They also assume that `bus_addr_i` and `bus_wdata_i` are stable at the edge where a strobe is sampled. The bench meets this by changing every input only on the falling clock edge and by raising each strobe for exactly one cycle. The bench never issues a read and a write in the same cycle. This keeps the one-cycle read latency and the write-then-status relation free of ordering effects.

// File: rtl/lms_pkg.sv
// Package: shared constants and types for the latch/monitor slice.
// Assumes a 16-bit register port with a 4-bit word address.
package lms_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;
    localparam int N_SPARE = 3;

    localparam logic [ADDR_W-1:0] A_CSR_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_CSR_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_TSR    = 4'd2;
    localparam logic [ADDR_W-1:0] A_SCR    = 4'd3;
    localparam logic [ADDR_W-1:0] A_MON_LO = 4'd8;
    localparam logic [ADDR_W-1:0] A_MON_HI = 4'd9;

    typedef struct packed {
        logic irq_req;
        logic irq_en;
    } csr_t;
endpackage

// File: rtl/lms_data_latch.sv
// Module: data latch plus monitor snapshot bank.
// The latch loads din_i on an edge where tick and enable are both high.
// The snapshot loads the pre-edge latch value on an edge with capture high.
// Assumes all strobes are synchronous to clk.
module lms_data_latch #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              tick_en_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [DATA_W-1:0] mon_o
);
    logic              load_en;
    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] mon_q;

    // Qualified load: tick gated by its enable.
    always_comb load_en = tick_i & tick_en_i;

    // Data latch: update only on a qualified tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load_en) begin
            latch_q <= din_i;
        end
    end

    // Snapshot bank: copy the current latch word on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else if (capture_i) begin
            mon_q <= latch_q;
        end
    end

    assign dout_o = latch_q;
    assign mon_o  = mon_q;
endmodule

// File: rtl/lms_ctrl_regs.sv
// Module: writable registers of the slice.
// Holds the interrupt enable/request pair and three spare words.
// Drives the active-low status line. Writes to other addresses are dropped.
module lms_ctrl_regs
    import lms_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [WORD_W-1:0]             wdata_i,
    output csr_t                          csr_o,
    output logic [N_SPARE-1:0][WORD_W-1:0] spare_o,
    output logic                          status_n_o
);
    csr_t csr_q;

    // Control/status word: bits 0 and 1 are writable, bit 2 is derived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (wr_i && addr_i == A_CSR_LO) begin
            csr_q.irq_en  <= wdata_i[0];
            csr_q.irq_req <= wdata_i[1];
        end
    end

    // Spare words at consecutive addresses after the control word.
    for (genvar i = 0; i < N_SPARE; i++) begin : g_spare
        localparam logic [ADDR_W-1:0] MY_ADDR = A_CSR_HI + ADDR_W'(i);
        logic [WORD_W-1:0] word_q;

        // Plain storage word with no side effect.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_i && addr_i == MY_ADDR) begin
                word_q <= wdata_i;
            end
        end

        assign spare_o[i] = word_q;
    end

    assign csr_o      = csr_q;
    assign status_n_o = ~(csr_q.irq_en & csr_q.irq_req);
endmodule

// File: rtl/lms_read_mux.sv
// Module: registered read path.
// Selects a word by address and pads the snapshot to two words with zeros.
// Returns data and a valid flag one cycle after the read strobe.
module lms_read_mux
    import lms_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  csr_t                           csr_i,
    input  logic [N_SPARE-1:0][WORD_W-1:0] spare_i,
    input  logic [DATA_W-1:0]              mon_i,
    output logic [WORD_W-1:0]              rdata_o,
    output logic                           rvalid_o
);
    localparam int MON_EXT_W = 2 * WORD_W;

    logic [MON_EXT_W-1:0] mon_ext;
    logic [WORD_W-1:0]    rd_word;
    logic [WORD_W-1:0]    rdata_q;
    logic                 rvalid_q;

    // Zero-extend the snapshot to two full words.
    if (DATA_W < MON_EXT_W) begin : g_pad
        assign mon_ext = {{(MON_EXT_W-DATA_W){1'b0}}, mon_i};
    end else begin : g_full
        assign mon_ext = mon_i[MON_EXT_W-1:0];
    end

    // Address decode for the read word.
    always_comb begin
        case (addr_i)
            A_CSR_LO: rd_word = {{(WORD_W-3){1'b0}},
                                 csr_i.irq_en & csr_i.irq_req,
                                 csr_i.irq_req, csr_i.irq_en};
            A_CSR_HI: rd_word = spare_i[0];
            A_TSR:    rd_word = spare_i[1];
            A_SCR:    rd_word = spare_i[2];
            A_MON_LO: rd_word = mon_ext[WORD_W-1:0];
            A_MON_HI: rd_word = mon_ext[MON_EXT_W-1:WORD_W];
            default:  rd_word = '0;
        endcase
    end

    // Read register: capture the word on a strobe, flag it valid one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_i;
            if (rd_i) begin
                rdata_q <= rd_word;
            end
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
endmodule

// File: rtl/latch_monitor_slice.sv
// Module: top of one latch slice.
// Joins the data latch, the control registers and the read path.
// Assumes a single clock domain and 1 <= DATA_W <= 32.
module latch_monitor_slice
    import lms_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              tick_en_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    input  logic [3:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [15:0]       bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [15:0]       bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              status_n_o
);
    logic [DATA_W-1:0]              mon;
    csr_t                           csr;
    logic [N_SPARE-1:0][WORD_W-1:0] spare;

    lms_data_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .tick_en_i (tick_en_i),
        .capture_i (capture_i),
        .din_i     (din_i),
        .dout_o    (dout_o),
        .mon_o     (mon)
    );

    lms_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .csr_o      (csr),
        .spare_o    (spare),
        .status_n_o (status_n_o)
    );

    lms_read_mux #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .csr_i    (csr),
        .spare_i  (spare),
        .mon_i    (mon),
        .rdata_o  (bus_rdata_o),
        .rvalid_o (bus_rvalid_o)
    );
endmodule

// File: rtl/lms_checker.sv
// Module: port-level properties of the latch slice, bound to the top.
// Assumes inputs are known and synchronous to clk.
module lms_checker #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              tick_en_i,
    input logic              capture_i,
    input logic [DATA_W-1:0] din_i,
    input logic [DATA_W-1:0] dout_o,
    input logic [3:0]        bus_addr_i,
    input logic              bus_wr_i,
    input logic [15:0]       bus_wdata_i,
    input logic              bus_rd_i,
    input logic [15:0]       bus_rdata_o,
    input logic              bus_rvalid_o,
    input logic              status_n_o
);
    logic unimpl_addr;
    assign unimpl_addr = (bus_addr_i >= 4'd4 && bus_addr_i <= 4'd7) ||
                         (bus_addr_i >= 4'd10);

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && tick_en_i) |=> (dout_o == $past(din_i)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && tick_en_i) |=> $stable(dout_o));

    a_r5_status_on: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 4'd0 && bus_wdata_i[1:0] == 2'b11) |=> !status_n_o);

    a_r5_status_off: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == 4'd0 && bus_wdata_i[1:0] != 2'b11) |=> status_n_o);

    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == 4'd0) |=> (bus_rdata_o[15:3] == 13'd0));

    a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && unimpl_addr) |=> (bus_rdata_o == 16'd0));

    a_r9_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);

    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> !bus_rvalid_o);

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (dout_o == '0 && status_n_o && !bus_rvalid_o));
endmodule

bind latch_monitor_slice lms_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_latch_monitor_slice.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_latch_monitor_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, tick_en = 1'b0, capture = 1'b0;
    logic [23:0] din = '0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;

    logic [23:0] dout;
    logic [15:0] rdata;
    logic        rvalid, status_n;
    logic [3:0]  dout1;
    logic [15:0] rdata1;
    logic        rvalid1, status_n1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    latch_monitor_slice #(.DATA_W(24)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tick_en_i(tick_en),
        .capture_i(capture), .din_i(din), .dout_o(dout),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rd_i(rd), .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
        .status_n_o(status_n)
    );

    latch_monitor_slice #(.DATA_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tick_en_i(tick_en),
        .capture_i(capture), .din_i(din[3:0]), .dout_o(dout1),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rd_i(rd), .bus_rdata_o(rdata1), .bus_rvalid_o(rvalid1),
        .status_n_o(status_n1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Read from both slices; data is sampled one cycle after the strobe.
    task automatic bus_read(input logic [3:0] a, output logic [15:0] d0, output logic [15:0] d1);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d0 = rdata; d1 = rdata1;
        chk("R9 rvalid after read", {31'd0, rvalid}, 32'd1);
    endtask

    task automatic do_tick(input logic [23:0] d, input logic en, input logic cap);
        @(negedge clk);
        din = d; tick = 1'b1; tick_en = en; capture = cap;
        @(negedge clk);
        tick = 1'b0; tick_en = 1'b0; capture = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] a, b;
        chk("R10 dout after reset", {8'd0, dout}, 32'd0);
        chk("R5 status_n high after reset", {31'd0, status_n}, 32'd1);
        chk("R9 rvalid low after reset", {31'd0, rvalid}, 32'd0);
        bus_read(4'd0, a, b);
        chk("R10 csr cleared", {16'd0, a}, 32'd0);
        bus_read(4'd8, a, b);
        chk("R10 snapshot cleared", {16'd0, a}, 32'd0);
    endtask

    task automatic t_load_hold();
        do_tick(24'hF1A2B3, 1'b1, 1'b0);
        chk("R1 load on enabled tick", {8'd0, dout}, 32'hF1A2B3);
        chk("R1 narrow slice load", {28'd0, dout1}, 32'h3);
        do_tick(24'h00FF00, 1'b0, 1'b0);
        chk("R2 hold when enable low", {8'd0, dout}, 32'hF1A2B3);
        @(negedge clk);
        din = 24'h777777; tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        chk("R2 hold when tick low", {8'd0, dout}, 32'hF1A2B3);
    endtask

    task automatic t_capture();
        logic [15:0] a, b;
        @(negedge clk);
        capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        do_tick(24'h123456, 1'b1, 1'b0);
        bus_read(4'd8, a, b);
        chk("R3 snapshot not live latch", {16'd0, a}, 32'hA2B3);
        chk("R7 narrow slice word 8 padded", {16'd0, b}, 32'h0003);
        bus_read(4'd9, a, b);
        chk("R7 word 9 upper bits zero", {16'd0, a}, 32'h00F1);
        chk("R7 narrow slice has no word 9", {16'd0, b}, 32'h0000);
        do_tick(24'hABCDEF, 1'b1, 1'b1);
        chk("R1 load with capture", {8'd0, dout}, 32'hABCDEF);
        bus_read(4'd8, a, b);
        chk("R3 same-cycle capture takes old word", {16'd0, a}, 32'h3456);
        bus_read(4'd9, a, b);
        chk("R3 same-cycle capture upper", {16'd0, a}, 32'h0012);
    endtask

    task automatic t_csr();
        logic [15:0] a, b;
        bus_write(4'd0, 16'hFFFF);
        bus_read(4'd0, a, b);
        chk("R4 csr readback with derived bit", {16'd0, a}, 32'h0007);
        chk("R5 status_n low when both set", {31'd0, status_n}, 32'd0);
        bus_write(4'd0, 16'h0001);
        bus_read(4'd0, a, b);
        chk("R4 enable only", {16'd0, a}, 32'h0001);
        chk("R5 status_n high with enable only", {31'd0, status_n}, 32'd1);
        bus_write(4'd0, 16'h0006);
        bus_read(4'd0, a, b);
        chk("R8 bit 2 write ignored", {16'd0, a}, 32'h0002);
        chk("R5 status_n high with request only", {31'd0, status_n}, 32'd1);
    endtask

    task automatic t_spare();
        logic [15:0] a, b;
        bus_write(4'd1, 16'h1234);
        bus_write(4'd2, 16'h5678);
        bus_write(4'd3, 16'h9ABC);
        bus_read(4'd1, a, b);
        chk("R6 word 1 readback", {16'd0, a}, 32'h1234);
        bus_read(4'd2, a, b);
        chk("R6 word 2 readback", {16'd0, a}, 32'h5678);
        bus_read(4'd3, a, b);
        chk("R6 word 3 readback", {16'd0, a}, 32'h9ABC);
        bus_read(4'd0, a, b);
        chk("R6 csr untouched", {16'd0, a}, 32'h0002);
        chk("R6 dout untouched", {8'd0, dout}, 32'hABCDEF);
    endtask

    task automatic t_unimpl();
        logic [15:0] a, b;
        bus_write(4'd8, 16'hFFFF);
        bus_write(4'd9, 16'hFFFF);
        bus_read(4'd8, a, b);
        chk("R8 write to word 8 ignored", {16'd0, a}, 32'h3456);
        bus_read(4'd9, a, b);
        chk("R8 write to word 9 ignored", {16'd0, a}, 32'h0012);
        bus_write(4'd5, 16'hFFFF);
        bus_read(4'd5, a, b);
        chk("R8 address 5 reads zero", {16'd0, a}, 32'd0);
        bus_read(4'd15, a, b);
        chk("R8 address 15 reads zero", {16'd0, a}, 32'd0);
        @(negedge clk);
        chk("R9 rvalid low without read", {31'd0, rvalid}, 32'd0);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_hold();
        t_capture();
        t_csr();
        t_spare();
        t_unimpl();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end
endmodule